// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a small data cache placed between a processor's byte-wide load/store port and a slower main-memory port that moves whole 64-bit blocks. It holds four lines of eight bytes each, and every memory block has exactly one line it can occupy. The byte address is split into three fields. The lowest three bits pick the byte within the block. The next two bits pick the line. The remaining upper bits are kept as the line's tag and compared on every access.

A load that hits returns its byte combinationally, in the same cycle as the request. A store that hits writes only the cached byte and marks the line dirty. On a miss, the processor's ready signal drops and a controller walks through the miss sequence. If the line being replaced holds modified data, that data is first written back to memory. The controller then fetches the requested block into the line. Once the refill is done, the held request completes as an ordinary hit. A store miss therefore allocates the line first and merges its byte afterwards. A clean victim is discarded without any memory write.

The processor must hold its request, address, direction and data stable while ready is low. Memory must answer each request with a one-cycle acknowledge. On a read, that acknowledge carries the block.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset all four lines are invalid. With no request pending, ready is high and the memory port is idle. The first access to any line is a miss.
- R2: The line is chosen by address bits [4:3] and the byte by bits [2:0]. Byte k of a line is bits [8k+7:8k] of the 64-bit block, and the upper bits [15:5] form the tag.
- R3: A load hit raises ready in the request cycle and returns the addressed byte in that cycle, with no memory request.
- R4: An access whose line is valid but whose tag (bits [15:5]) differs from the stored tag is a miss.
- R5: A store hit updates only the cached byte, with no memory traffic, and marks the line dirty.
- R6: On a miss whose victim is valid and dirty, the victim block is written to memory before the refill. The write carries mem_we=1, address {victim tag, index, 000}, and the victim's current contents as data.
- R7: On a miss whose victim is clean or invalid, no memory write occurs, and exactly one block read (mem_we=0) refills the line.
- R8: A store miss first fetches the block and then merges the store byte. The other seven bytes keep the fetched memory values, and the line becomes dirty.
- R9: While a miss is in progress, ready stays low. mem_req, mem_addr and mem_we hold until mem_ack. The held request completes on the cycle after the refill acknowledge.
- R10: Every memory-port address is block aligned, meaning bits [2:0] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = store byte, 0 = load byte |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 8 | Store data |
| cpu_rdata | output | 8 | Load data, valid when ready and request are high |
| cpu_ready | output | 1 | Access completes this cycle (high when idle) |
| mem_req | output | 1 | Memory transfer request, held until acknowledge |
| mem_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | 16 | Block-aligned memory address |
| mem_wdata | output | 64 | Block being written back |
| mem_rdata | input | 64 | Block returned by memory, valid with acknowledge |
| mem_ack | input | 1 | One-cycle transfer acknowledge |

## Verification
Two events meet on the cycle of the refill acknowledge: the new block arrives in the line, and the held processor request is looked up again. Ready must still be low in that cycle and high in the next, with the merged store or the loaded byte visible. The bench provokes this on every miss, across store misses to dirty and clean lines. It varies the memory response delay from zero to three cycles, so the acknowledge also lands directly after the write-back acknowledge. Each access is judged against a bench-side model of tags, valid and dirty bits and of the memory image. That model predicts the hit or miss outcome, the loaded byte, and the exact address and data of each write-back.

// File: rtl/cache_pkg.sv
// Shared types for the direct-mapped write-back cache.
// Assumes: nothing beyond the parameters of the top module.
package cache_pkg;

    // Miss-handling controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } ctrl_state_e;

endpackage

// File: rtl/cache_tag_store.sv
// Tag, valid and dirty storage, one entry per line.
// Assumes: LINES is a power of two, and fill and dirty-marking never target
// the same line in the same cycle (fill takes priority if they do).
module cache_tag_store #(
    parameter int LINES = 4,
    parameter int TAG_W = 11,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_dirty,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty
);

    logic [TAG_W-1:0] tag_arr   [LINES];
    logic             valid_arr [LINES];
    logic             dirty_arr [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [TAG_W-1:0] tag_q;
        logic             valid_q;
        logic             dirty_q;
        logic             sel;

        assign sel = (idx == IDX_W'(g));

        // Per-line state: fill installs a clean valid tag, a store hit sets dirty
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q   <= '0;
                valid_q <= 1'b0;
                dirty_q <= 1'b0;
            end else if (fill_en && sel) begin
                tag_q   <= fill_tag;
                valid_q <= 1'b1;
                dirty_q <= 1'b0;
            end else if (mark_dirty && sel) begin
                dirty_q <= 1'b1;
            end
        end

        assign tag_arr[g]   = tag_q;
        assign valid_arr[g] = valid_q;
        assign dirty_arr[g] = dirty_q;
    end

    // Read port for the currently indexed line
    always_comb begin
        rd_tag   = tag_arr[idx];
        rd_valid = valid_arr[idx];
        rd_dirty = dirty_arr[idx];
    end

endmodule

// File: rtl/cache_data_store.sv
// Line data storage with a whole-line fill port and a single-byte write port.
// Assumes: LINES and LINE_BYTES are powers of two; byte k of a line sits at
// bits [8k+7:8k].
module cache_data_store #(
    parameter int LINES      = 4,
    parameter int LINE_BYTES = 8,
    localparam int IDX_W  = $clog2(LINES),
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LINE_W = 8 * LINE_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFF_W-1:0]  off,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_data,
    input  logic              byte_we,
    input  logic [7:0]        byte_data,
    output logic [LINE_W-1:0] rd_line,
    output logic [7:0]        rd_byte
);

    logic [LINE_W-1:0] line_arr [LINES];
    logic [LINE_W-1:0] shifted;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [LINE_W-1:0] data_q;
        logic              sel;

        assign sel = (idx == IDX_W'(g));

        // Line contents: a refill replaces the line, a store writes one byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q <= '0;
            end else if (fill_en && sel) begin
                data_q <= fill_data;
            end else if (byte_we && sel) begin
                for (int b = 0; b < LINE_BYTES; b++) begin
                    if (off == OFF_W'(b)) begin
                        data_q[8*b +: 8] <= byte_data;
                    end
                end
            end
        end

        assign line_arr[g] = data_q;
    end

    // Read port: full line for write-back, selected byte for loads
    always_comb begin
        rd_line = line_arr[idx];
        shifted = rd_line >> {off, 3'b000};
        rd_byte = shifted[7:0];
    end

endmodule

// File: rtl/cache_ctrl.sv
// Miss-handling controller: idle, optional write-back of a dirty victim,
// then refill, then back to idle where the held request completes as a hit.
// Assumes: the processor holds its request stable until ready, and memory
// answers each request with a single-cycle acknowledge.
module cache_ctrl
    import cache_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic        hit,
    input  logic        victim_dirty,
    input  logic        mem_ack,
    output ctrl_state_e state,
    output logic        idle,
    output logic        fill_en,
    output logic        mem_req,
    output logic        mem_we
);

    ctrl_state_e state_q, state_d;

    // Next-state selection for the miss sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cpu_req && !hit) state_d = victim_dirty ? ST_WBACK : ST_FILL;
            ST_WBACK: if (mem_ack) state_d = ST_FILL;
            ST_FILL:  if (mem_ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Memory-port and storage controls decoded from the state
    always_comb begin
        state   = state_q;
        idle    = (state_q == ST_IDLE);
        mem_req = (state_q == ST_WBACK) || (state_q == ST_FILL);
        mem_we  = (state_q == ST_WBACK);
        fill_en = (state_q == ST_FILL) && mem_ack;
    end

endmodule

// File: rtl/dm_wb_cache.sv
// Direct-mapped write-back, write-allocate data cache with byte-wide
// processor access and whole-block memory transfers.
// Assumes: ADDR_W > index + offset widths; processor holds request until
// ready; memory acknowledges each request for exactly one cycle.
module dm_wb_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINES      = 4,
    parameter int LINE_BYTES = 8,
    localparam int IDX_W  = $clog2(LINES),
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int LINE_W = 8 * LINE_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic [LINE_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    logic [OFF_W-1:0]  a_off;
    logic [IDX_W-1:0]  a_idx;
    logic [TAG_W-1:0]  a_tag;
    logic [TAG_W-1:0]  line_tag;
    logic              line_valid;
    logic              line_dirty;
    logic              hit;
    logic              idle;
    logic              fill_en;
    logic              store_hit;
    logic [LINE_W-1:0] line_data;
    ctrl_state_e       state;

    // Address field split
    always_comb begin
        a_off = cpu_addr[OFF_W-1:0];
        a_idx = cpu_addr[OFF_W +: IDX_W];
        a_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    end

    cache_tag_store #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (a_idx),
        .fill_en    (fill_en),
        .fill_tag   (a_tag),
        .mark_dirty (store_hit),
        .rd_tag     (line_tag),
        .rd_valid   (line_valid),
        .rd_dirty   (line_dirty)
    );

    cache_data_store #(
        .LINES      (LINES),
        .LINE_BYTES (LINE_BYTES)
    ) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (a_idx),
        .off       (a_off),
        .fill_en   (fill_en),
        .fill_data (mem_rdata),
        .byte_we   (store_hit),
        .byte_data (cpu_wdata),
        .rd_line   (line_data),
        .rd_byte   (cpu_rdata)
    );

    cache_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .hit          (hit),
        .victim_dirty (line_valid && line_dirty),
        .mem_ack      (mem_ack),
        .state        (state),
        .idle         (idle),
        .fill_en      (fill_en),
        .mem_req      (mem_req),
        .mem_we       (mem_we)
    );

    // Hit check and processor-side handshake
    always_comb begin
        hit       = line_valid && (line_tag == a_tag);
        cpu_ready = idle && (!cpu_req || hit);
        store_hit = idle && cpu_req && cpu_we && hit;
    end

    // Memory address: victim block during write-back, requested block otherwise
    always_comb begin
        if (state == ST_WBACK) mem_addr = {line_tag, a_idx, {OFF_W{1'b0}}};
        else                   mem_addr = {a_tag,    a_idx, {OFF_W{1'b0}}};
        mem_wdata = line_data;
    end

endmodule

// File: rtl/cache_checker.sv
// Protocol and sequencing checks for dm_wb_cache, attached by bind.
// Assumes: the processor holds its request stable while ready is low.
module cache_checker #(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 8,
    localparam int OFF_W = $clog2(LINE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr
);

    p_busy_ready_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_fill_completes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && cpu_req) |=> cpu_ready);

    p_wb_before_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    p_hit_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready) |-> !mem_req);

    p_block_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

endmodule

bind dm_wb_cache cache_checker #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr)
);

// File: tb/dm_wb_cache_bench.sv
// Self-checking bench: sweeps addresses over a 2 KB window against a model
// of tags, valid/dirty bits and a block memory image.
module dm_wb_cache_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NBLK       = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dm_wb_cache u_dm_wb_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Memory model state
    logic [63:0] bmem [NBLK];
    int          mem_dly = 0;
    int          dcnt = 0;
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    int          addr_bad = 0;
    logic [15:0] last_wr_addr = '0;
    logic [63:0] last_wr_data = '0;

    function automatic logic [63:0] init_blk(int b);
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[8*k +: 8] = 8'((b * 8 + k) * 7 + 3);
        return v;
    endfunction

    // Block memory with programmable acknowledge delay
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) bmem[i] <= init_blk(i);
            mem_ack <= 1'b0;
            dcnt    <= 0;
        end else if (mem_req && mem_ack) begin
            mem_ack <= 1'b0;
            dcnt    <= 0;
            if (mem_addr[2:0] != 3'b000 || mem_addr[15:11] != 5'b0) addr_bad <= addr_bad + 1;
            if (mem_we) begin
                bmem[mem_addr[10:3]] <= mem_wdata;
                wr_cnt       <= wr_cnt + 1;
                last_wr_addr <= mem_addr;
                last_wr_data <= mem_wdata;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
        end else if (mem_req) begin
            if (dcnt >= mem_dly) begin
                mem_ack   <= 1'b1;
                mem_rdata <= bmem[mem_addr[10:3]];
            end else begin
                dcnt <= dcnt + 1;
            end
        end
    end

    // Reference model of the cache contents as the processor sees them
    logic [63:0] gold [NBLK];
    int          mt [4];
    bit          mv [4];
    bit          md [4];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [15:0] a, input logic [7:0] d);
        int idx  = int'(a[4:3]);
        int tg   = int'(a[15:5]);
        int blk  = int'(a[10:3]);
        int off  = int'(a[2:0]);
        bit ehit = mv[idx] && (mt[idx] == tg);
        bit ewb  = !ehit && mv[idx] && md[idx];
        int vblk = mt[idx] * 4 + idx;
        int wr0  = wr_cnt;
        int rd0  = rd_cnt;
        int waits = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        #1;
        if (ehit)         chk(cpu_ready == 1'b1, "R3 hit ready in request cycle", 64'(cpu_ready), 64'd1);
        else if (mv[idx]) chk(cpu_ready == 1'b0, "R4 tag mismatch misses", 64'(cpu_ready), 64'd0);
        else              chk(cpu_ready == 1'b0, "R1 invalid line misses", 64'(cpu_ready), 64'd0);
        while (!cpu_ready && waits < 200) begin
            @(negedge clk); #1; waits++;
        end
        if (!we) chk(cpu_rdata == gold[blk][8*off +: 8], "R2 load byte", 64'(cpu_rdata), 64'(gold[blk][8*off +: 8]));
        @(posedge clk); #1;
        cpu_req = 1'b0;
        if (ehit) begin
            chk((wr_cnt == wr0) && (rd_cnt == rd0), we ? "R5 store hit no memory traffic" : "R3 load hit no memory traffic",
                64'(wr_cnt - wr0 + rd_cnt - rd0), 64'd0);
        end else begin
            chk(rd_cnt == rd0 + 1, "R7 one refill read", 64'(rd_cnt - rd0), 64'd1);
            chk(waits >= 2, "R9 ready low through miss", 64'(waits), 64'd2);
            if (ewb) begin
                chk(wr_cnt == wr0 + 1, "R6 dirty victim written", 64'(wr_cnt - wr0), 64'd1);
                chk(last_wr_addr == 16'(vblk * 8), "R6 write-back address", 64'(last_wr_addr), 64'(vblk * 8));
                chk(last_wr_data == gold[vblk], "R6 write-back data", last_wr_data, gold[vblk]);
            end else begin
                chk(wr_cnt == wr0, "R7 clean victim dropped", 64'(wr_cnt - wr0), 64'd0);
            end
        end
        if (!ehit) md[idx] = 1'b0;
        mv[idx] = 1'b1;
        mt[idx] = tg;
        if (we) begin
            md[idx] = 1'b1;
            gold[blk][8*off +: 8] = d;
        end
    endtask

    // Watchdog: a hung run is a failure that still reaches the summary
    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < NBLK; i++) gold[i] = init_blk(i);
        for (int i = 0; i < 4; i++) begin mv[i] = 1'b0; md[i] = 1'b0; mt[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(cpu_ready == 1'b1, "R1 reset ready idle", 64'(cpu_ready), 64'd1);
        chk(mem_req == 1'b0, "R1 reset memory idle", 64'(mem_req), 64'd0);

        // Loads over blocks 0..7: compulsory misses, then hits on every byte (R2)
        for (int a = 0; a < 64; a++) access(1'b0, 16'(a), 8'h00);
        // Store hits to the resident blocks 4..7 (R5)
        for (int a = 32; a < 64; a++) access(1'b1, 16'(a), 8'(a) ^ 8'h3C);
        // Conflicting tags evict the dirty lines (R4, R6)
        for (int a = 256; a < 288; a++) access(1'b0, 16'(a), 8'h00);
        // Store misses to clean lines, then read back the merged line (R8)
        for (int i = 0; i < 4; i++) begin
            int base = 512 + i * 8;
            access(1'b1, 16'(base + 5), 8'hC0 + 8'(i));
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'(base + k); #1;
                chk(cpu_ready == 1'b1, "R8 allocated line hits", 64'(cpu_ready), 64'd1);
                chk(cpu_rdata == gold[(base >> 3)][8*k +: 8], "R8 merged line contents",
                    64'(cpu_rdata), 64'(gold[(base >> 3)][8*k +: 8]));
                @(posedge clk); #1; cpu_req = 1'b0;
            end
        end
        // Store miss onto dirty lines: write-back then allocate (R6, R8)
        for (int i = 0; i < 4; i++) access(1'b1, 16'(1024 + i * 8 + 2), 8'h90 + 8'(i));
        for (int i = 0; i < 4; i++) access(1'b0, 16'(1024 + i * 8 + 2), 8'h00);

        // Mixed sweep with varying memory delay
        lfsr = 16'hACE1;
        for (int n = 0; n < 1500; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_dly = int'(lfsr[14:13]);
            access(lfsr[12], {5'b0, lfsr[10:0]}, lfsr[7:0] ^ 8'h5A);
        end
        @(negedge clk);
        chk(addr_bad == 0, "R10 block aligned memory addresses", 64'(addr_bad), 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule